// File: doc/BRIEF.md
# Multi-Mode Waveform Timer

This block is an 8-bit counter that advances on ticks from a selectable source: the system clock divided by one of several ratios, or edges on an external count pin. It compares the count with one compare register. From that comparison it drives a single waveform pin in one of four modes. The modes are free-running with overflow, clear-on-match, single-slope fast PWM and dual-slope phase-correct PWM. In the dual-slope mode the count sits at its maximum for one tick and at zero for one tick.

Two events are flagged: overflow and compare match. Each flag raises an interrupt request only when its enable bit is set. Software clears a flag by writing 1 to it. A small register port gives software access to the control fields, the count, the compare value and the flag/enable byte. There is no data stream through the block, so every pin is a plain control or status signal.

Top module: `wavetimer`

## Requirements
- R1: After reset the count, the compare value, the control byte, the flags and the enables all read 0. The waveform pin and both interrupt requests are low.
- R2: The tick source is control bits [6:4]. Code 0 stops the count. Code 1 ticks every clock. Codes 2, 3, 4 and 5 tick once every 8, 64, 256 and 1024 clocks, when the low 3, 6, 8 or 10 bits of a free-running prescaler are all ones. Code 7 ticks on a rising edge and code 6 on a falling edge of the external pin, both seen after a two-flop synchronizer.
- R3: Mode code 0 (control bits [1:0]) counts up and wraps from 255 to 0. The overflow flag (flag byte bit 0) sets on each tick taken at 255.
- R4: The compare flag (flag byte bit 1) sets on a tick taken while the count equals the active compare value.
- R5: Mode code 2 returns the count to 0 on the tick after it equals the active compare value, so the period is compare+1 ticks.
- R6: Mode code 3 counts 0 to 255 and wraps. With output code 2 (control bits [3:2]) the pin goes low on a match and high on the tick at 255. A wrap overrides a match in the same tick. Output code 3 gives the inverse.
- R7: Mode code 1 counts up to 255, holds 255 for one tick, then counts down to 0, holds 0 for one tick, and repeats. Overflow sets on a tick taken at 0. With output code 2, a match while rising drives the pin low and a match while falling drives it high. Code 3 inverts this.
- R8: In the PWM modes (1 and 3), a compare write goes to a buffer that reads back at address 2 at once. The active value takes the buffer on the tick taken at 255. In modes 0 and 2 the write takes effect at once.
- R9: In modes 0 and 2, output code 1 toggles the pin on each match, code 2 clears it and code 3 sets it. Output code 0 holds the pin low in every mode, and code 1 holds it low in the PWM modes.
- R10: A count write (address 1) wins over counting in its cycle, and that cycle raises no event. The next tick raises no compare flag and does not change the pin on a match, though clear-on-match still clears the count.
- R11: Writing the flag byte (address 3) clears each flag whose data bit is 1 (bit 0 overflow, bit 1 compare). A flag set in the same cycle stays set.
- R12: The overflow request is high while flag bit 0 and enable bit 2 of the flag byte are both 1. The compare request is high while flag bit 1 and enable bit 3 are both 1. Enables are loaded on every flag-byte write.
- R13: The register map is address 0 control (cs[6:4], output code [3:2], mode [1:0], bit 7 reads 0), address 1 count, address 2 compare buffer, and address 3 flag byte (bits 7:4 read 0). Reads are combinational from the read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_cnt_i | input | 1 | External count source, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 2 | Write address |
| reg_wdata_i | input | 8 | Write data |
| reg_raddr_i | input | 2 | Read address |
| reg_rdata_o | output | 8 | Read data |
| wave_o | output | 1 | Waveform pin |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| irq_cmp_o | output | 1 | Compare interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit count, a 10-bit prescaler and a two-stage synchronizer. With these values one full ramp takes 256 ticks and one dual-slope period takes 510 ticks. A few thousand clock-rate ticks therefore pass through the 255 dwell, the zero dwell and every buffer update many times. The slowest divider, 1024, still gives several ticks inside a short run. The bench also pulses the external pin at both edge polarities, so the synchronizer delay is checked against a counted result.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic [1:0] {
    WM_FREE  = 2'd0,
    WM_DUAL  = 2'd1,
    WM_CLEAR = 2'd2,
    WM_SLOPE = 2'd3
  } wmode_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_CMP  = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

  function automatic logic is_pwm(input wmode_t m);
    return (m == WM_DUAL) || (m == WM_SLOPE);
  endfunction
endpackage

// File: rtl/wt_tick_gen.sv
module wt_tick_gen #(
  parameter int L_DIV_A = 3,
  parameter int L_DIV_B = 6,
  parameter int L_DIV_C = 8,
  parameter int L_DIV_D = 10,
  parameter int SYNC_N  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       ext_in,
  output logic       tick
);
  localparam int PSC_W = L_DIV_D;

  logic [PSC_W-1:0]  psc;
  logic [SYNC_N-1:0] sy;
  logic              prev;
  logic              synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc <= '0;
    else        psc <= psc + PSC_W'(1);
  end

  generate
    if (SYNC_N == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy <= '0;
        else        sy <= ext_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy <= '0;
        else        sy <= {sy[SYNC_N-2:0], ext_in};
      end
    end
  endgenerate

  assign synced = sy[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= synced;
  end

  always_comb begin
    unique case (sel)
      3'd0: tick = 1'b0;
      3'd1: tick = 1'b1;
      3'd2: tick = &psc[L_DIV_A-1:0];
      3'd3: tick = &psc[L_DIV_B-1:0];
      3'd4: tick = &psc[L_DIV_C-1:0];
      3'd5: tick = &psc[L_DIV_D-1:0];
      3'd6: tick = prev & ~synced;
      default: tick = synced & ~prev;
    endcase
  end
endmodule

// File: rtl/wt_core.sv
module wt_core
  import wt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  wmode_t       mode,
  input  logic         cnt_wr,
  input  logic         cmp_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cmp_buf,
  output logic [W-1:0] cmp_act,
  output logic         down,
  output logic         cmp_evt,
  output logic         ovf_evt,
  output logic         wrap_evt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);

  logic adv;
  logic hush;
  logic at_max;
  logic at_min;
  logic eq;

  assign adv    = tick & ~cnt_wr;
  assign at_max = (cnt == MAXV);
  assign at_min = (cnt == '0);
  assign eq     = (cnt == cmp_act);

  assign cmp_evt  = adv & eq & ~hush;
  assign wrap_evt = adv & at_max;
  assign ovf_evt  = adv & ((mode == WM_DUAL) ? at_min : at_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (cnt_wr) begin
      cnt <= wdata;
      if (mode != WM_DUAL) down <= 1'b0;
    end else if (mode != WM_DUAL) begin
      down <= 1'b0;
      if (tick) begin
        if (mode == WM_CLEAR && eq) cnt <= '0;
        else                        cnt <= cnt + ONE;
      end
    end else if (tick) begin
      if (!down) begin
        if (at_max) begin
          cnt  <= MAXV - ONE;
          down <= 1'b1;
        end else begin
          cnt  <= cnt + ONE;
          down <= (cnt == MAXV - ONE);
        end
      end else begin
        if (at_min) begin
          cnt  <= ONE;
          down <= 1'b0;
        end else begin
          cnt  <= cnt - ONE;
          down <= (cnt != ONE);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hush <= 1'b0;
    else if (cnt_wr) hush <= 1'b1;
    else if (tick)   hush <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_buf <= '0;
      cmp_act <= '0;
    end else begin
      if (cmp_wr) cmp_buf <= wdata;
      if (!is_pwm(mode))      cmp_act <= cmp_wr ? wdata : cmp_buf;
      else if (wrap_evt)      cmp_act <= cmp_buf;
    end
  end
endmodule

// File: rtl/wt_wave.sv
module wt_wave
  import wt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  wmode_t     mode,
  input  logic [1:0] oc,
  input  logic       cmp_evt,
  input  logic       wrap_evt,
  input  logic       down,
  output logic       pin
);
  logic lvl;
  logic muted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= 1'b0;
    end else begin
      unique case (mode)
        WM_FREE, WM_CLEAR: begin
          if (cmp_evt) begin
            unique case (oc)
              2'd1: lvl <= ~lvl;
              2'd2: lvl <= 1'b0;
              2'd3: lvl <= 1'b1;
              default: lvl <= lvl;
            endcase
          end
        end
        WM_SLOPE: begin
          if (oc[1]) begin
            if (wrap_evt)     lvl <= ~oc[0];
            else if (cmp_evt) lvl <= oc[0];
          end
        end
        default: begin
          if (oc[1] && cmp_evt) lvl <= down ? ~oc[0] : oc[0];
        end
      endcase
    end
  end

  assign muted = (oc == 2'd0) || (is_pwm(mode) && oc == 2'd1);
  assign pin   = muted ? 1'b0 : lvl;
endmodule

// File: rtl/wavetimer.sv
module wavetimer
  import wt_pkg::*;
#(
  parameter int W      = 8,
  parameter int SYNC_N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_cnt_i,
  input  logic         reg_wr_i,
  input  logic [1:0]   reg_waddr_i,
  input  logic [W-1:0] reg_wdata_i,
  input  logic [1:0]   reg_raddr_i,
  output logic [W-1:0] reg_rdata_o,
  output logic         wave_o,
  output logic         irq_ovf_o,
  output logic         irq_cmp_o
);
  logic [2:0]   cs;
  logic [1:0]   oc;
  wmode_t       mode;
  logic         tick;
  logic         ctrl_wr, cnt_wr, cmp_wr, flag_wr;
  logic [W-1:0] cnt, cmp_buf, cmp_act;
  logic         down, cmp_evt, ovf_evt, wrap_evt;
  logic         f_ovf, f_cmp, en_ovf, en_cmp;

  assign ctrl_wr = reg_wr_i && reg_waddr_i == A_CTRL;
  assign cnt_wr  = reg_wr_i && reg_waddr_i == A_CNT;
  assign cmp_wr  = reg_wr_i && reg_waddr_i == A_CMP;
  assign flag_wr = reg_wr_i && reg_waddr_i == A_FLAG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs   <= '0;
      oc   <= '0;
      mode <= WM_FREE;
    end else if (ctrl_wr) begin
      cs   <= reg_wdata_i[6:4];
      oc   <= reg_wdata_i[3:2];
      mode <= wmode_t'(reg_wdata_i[1:0]);
    end
  end

  wt_tick_gen #(.SYNC_N(SYNC_N)) tick_i (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (cs),
    .ext_in(ext_cnt_i),
    .tick  (tick)
  );

  wt_core #(.W(W)) core_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .mode    (mode),
    .cnt_wr  (cnt_wr),
    .cmp_wr  (cmp_wr),
    .wdata   (reg_wdata_i),
    .cnt     (cnt),
    .cmp_buf (cmp_buf),
    .cmp_act (cmp_act),
    .down    (down),
    .cmp_evt (cmp_evt),
    .ovf_evt (ovf_evt),
    .wrap_evt(wrap_evt)
  );

  wt_wave wave_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .oc      (oc),
    .cmp_evt (cmp_evt),
    .wrap_evt(wrap_evt),
    .down    (down),
    .pin     (wave_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_ovf  <= 1'b0;
      f_cmp  <= 1'b0;
      en_ovf <= 1'b0;
      en_cmp <= 1'b0;
    end else begin
      f_ovf <= ovf_evt | (f_ovf & ~(flag_wr & reg_wdata_i[0]));
      f_cmp <= cmp_evt | (f_cmp & ~(flag_wr & reg_wdata_i[1]));
      if (flag_wr) begin
        en_ovf <= reg_wdata_i[2];
        en_cmp <= reg_wdata_i[3];
      end
    end
  end

  assign irq_ovf_o = f_ovf & en_ovf;
  assign irq_cmp_o = f_cmp & en_cmp;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_raddr_i)
      A_CTRL: reg_rdata_o[6:0] = {cs, oc, mode};
      A_CNT:  reg_rdata_o = cnt;
      A_CMP:  reg_rdata_o = cmp_buf;
      default: reg_rdata_o[3:0] = {en_cmp, en_ovf, f_cmp, f_ovf};
    endcase
  end
endmodule

// File: rtl/wt_checker.sv
module wt_checker
  import wt_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   cs,
  input wmode_t       mode,
  input logic         tick,
  input logic         cnt_wr,
  input logic         flag_wr,
  input logic         clr_ovf_bit,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cmp_act,
  input logic         cmp_evt,
  input logic         ovf_evt,
  input logic         f_ovf
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs == 3'd0 && !cnt_wr) |=> $stable(cnt)); // R2

  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_CLEAR && tick && !cnt_wr && cnt == cmp_act) |=> cnt == '0); // R5

  AST_SLOPE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_SLOPE && tick && !cnt_wr && cnt == MAXV) |=> cnt == '0); // R6

  AST_DUAL_TOP_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_DUAL && tick && !cnt_wr && cnt == MAXV) |=> cnt == MAXV - W'(1)); // R7

  AST_WRITE_HUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_wr) && tick) |-> !cmp_evt); // R10

  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && clr_ovf_bit && !ovf_evt) |=> !f_ovf); // R11
endmodule

bind wavetimer wt_checker #(.W(W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs         (cs),
  .mode       (mode),
  .tick       (tick),
  .cnt_wr     (cnt_wr),
  .flag_wr    (flag_wr),
  .clr_ovf_bit(reg_wdata_i[0]),
  .cnt        (cnt),
  .cmp_act    (cmp_act),
  .cmp_evt    (cmp_evt),
  .ovf_evt    (ovf_evt),
  .f_ovf      (f_ovf)
);

// File: tb/wavetimer_tb_top.sv
`timescale 1ns/1ps
module wavetimer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] waddr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [1:0] raddr = 2'd1;
  logic [7:0] rdata;
  logic       wave, irq_o, irq_c;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wavetimer dut_i (
    .clk(clk), .rst_n(rst_n), .ext_cnt_i(ext),
    .reg_wr_i(wr), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
    .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .wave_o(wave), .irq_ovf_o(irq_o), .irq_cmp_o(irq_c)
  );

  // behavioural reference state
  int m_cnt, m_dn, m_hush, m_buf, m_act, m_fo, m_fc, m_eo, m_ec, m_lvl;
  int m_mode, m_oc, m_cs, m_psc, m_s1, m_s2, m_pv;
  int t_tk, t_cmp, t_ovf, t_wrap, t_wc, n_cnt, n_dn;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_dn = 0; m_hush = 0; m_buf = 0; m_act = 0;
      m_fo = 0; m_fc = 0; m_eo = 0; m_ec = 0; m_lvl = 0;
      m_mode = 0; m_oc = 0; m_cs = 0; m_psc = 0; m_s1 = 0; m_s2 = 0; m_pv = 0;
    end else begin
      case (m_cs)
        0: t_tk = 0;
        1: t_tk = 1;
        2: t_tk = (m_psc % 8) == 7;
        3: t_tk = (m_psc % 64) == 63;
        4: t_tk = (m_psc % 256) == 255;
        5: t_tk = (m_psc % 1024) == 1023;
        6: t_tk = (m_pv == 1 && m_s2 == 0);
        default: t_tk = (m_s2 == 1 && m_pv == 0);
      endcase
      t_wc   = (wr && waddr == 2'd1);
      t_cmp  = t_tk && !t_wc && m_cnt == m_act && !m_hush;
      t_wrap = t_tk && !t_wc && m_cnt == 255;
      t_ovf  = t_tk && !t_wc && ((m_mode == 1) ? (m_cnt == 0) : (m_cnt == 255));
      n_cnt = m_cnt; n_dn = m_dn;
      if (t_wc) begin
        n_cnt = wdata;
        if (m_mode != 1) n_dn = 0;
      end else if (m_mode != 1) begin
        n_dn = 0;
        if (t_tk) n_cnt = (m_mode == 2 && m_cnt == m_act) ? 0 : (m_cnt + 1) % 256;
      end else if (t_tk) begin
        if (m_dn == 0) begin
          if (m_cnt == 255) begin n_cnt = 254; n_dn = 1; end
          else begin n_cnt = m_cnt + 1; n_dn = (n_cnt == 255); end
        end else begin
          if (m_cnt == 0) begin n_cnt = 1; n_dn = 0; end
          else begin n_cnt = m_cnt - 1; n_dn = (n_cnt != 0); end
        end
      end
      // waveform level
      if (m_mode == 0 || m_mode == 2) begin
        if (t_cmp) begin
          if (m_oc == 1) m_lvl = 1 - m_lvl;
          else if (m_oc == 2) m_lvl = 0;
          else if (m_oc == 3) m_lvl = 1;
        end
      end else if (m_mode == 3) begin
        if (m_oc >= 2) begin
          if (t_wrap) m_lvl = (m_oc == 2);
          else if (t_cmp) m_lvl = (m_oc == 3);
        end
      end else begin
        if (m_oc >= 2 && t_cmp) m_lvl = m_dn ? (m_oc == 2) : (m_oc == 3);
      end
      // compare value
      if (m_mode == 0 || m_mode == 2) m_act = (wr && waddr == 2'd2) ? wdata : m_buf;
      else if (t_wrap) m_act = m_buf;
      if (wr && waddr == 2'd2) m_buf = wdata;
      // hush after count write
      if (t_wc) m_hush = 1; else if (t_tk) m_hush = 0;
      // flags
      m_fo = t_ovf || (m_fo && !(wr && waddr == 2'd3 && wdata[0]));
      m_fc = t_cmp || (m_fc && !(wr && waddr == 2'd3 && wdata[1]));
      if (wr && waddr == 2'd3) begin m_eo = wdata[2]; m_ec = wdata[3]; end
      if (wr && waddr == 2'd0) begin
        m_cs = wdata[6:4]; m_oc = wdata[3:2]; m_mode = wdata[1:0];
      end
      m_cnt = n_cnt; m_dn = n_dn;
      m_psc = (m_psc + 1) % 1024;
      m_pv = m_s2; m_s2 = m_s1; m_s1 = ext;
    end
  end

  function automatic int exp_rd(input int a);
    case (a)
      0: return (m_cs << 4) | (m_oc << 2) | m_mode;
      1: return m_cnt;
      2: return m_buf;
      default: return (m_ec << 3) | (m_eo << 2) | (m_fc << 1) | m_fo;
    endcase
  endfunction

  function automatic string cnt_tag(input int md);
    case (md)
      0: return "R3";
      1: return "R7";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic string pin_tag(input int md);
    case (md)
      1: return "R7";
      3: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference, away from the edge
  always begin
    @(posedge clk);
    #3;
    if (rst_n && !done) begin
      chk(rdata == exp_rd(raddr), (raddr == 1) ? cnt_tag(m_mode) : "R13", rdata, exp_rd(raddr));
      chk(wave == m_lvl && !(m_oc == 0 || ((m_mode == 1 || m_mode == 3) && m_oc == 1))
          || wave == 0 && (m_oc == 0 || ((m_mode == 1 || m_mode == 3) && m_oc == 1)),
          pin_tag(m_mode), wave, m_lvl);
      chk(irq_o == (m_fo && m_eo), "R12", irq_o, m_fo && m_eo);
      chk(irq_c == (m_fc && m_ec), "R12", irq_c, m_fc && m_ec);
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; waddr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [1:0] a, input int e, input string tag);
    @(negedge clk); raddr = a;
    @(posedge clk); #3;
    chk(rdata == e[7:0], tag, rdata, e);
    @(negedge clk); raddr = 2'd1;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext = 1'b1; idle(3);
      ext = 1'b0; idle(3);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    idle(4);
    // R1: reset state observed while reset is held
    chk(wave == 0 && irq_o == 0 && irq_c == 0, "R1", {wave, irq_o, irq_c}, 0);
    rst_n = 1'b1;
    rd_chk(0, 0, "R1"); rd_chk(1, 0, "R1"); rd_chk(2, 0, "R1"); rd_chk(3, 0, "R1");

    // free-running mode with toggle output, both requests enabled (R3, R4, R9, R12)
    reg_write(2'd3, 8'h0C);
    reg_write(2'd2, 8'h80);
    reg_write(2'd0, 8'h14);
    idle(600);
    // R10: count write lands on the compare value, match is hushed
    reg_write(2'd1, 8'h80);
    idle(300);
    // stop the tick, then flag clearing (R11)
    reg_write(2'd0, 8'h04);
    rd_chk(3, 8'h0F, "R11");
    reg_write(2'd3, 8'h0D);
    rd_chk(3, 8'h0E, "R11");
    reg_write(2'd3, 8'h0E);
    rd_chk(3, 8'h0C, "R11");
    rd_chk(0, 8'h04, "R13");

    // clear-on-match mode, three output codes (R5, R9)
    reg_write(2'd2, 8'd20);
    reg_write(2'd1, 8'd0);
    reg_write(2'd0, 8'h16);
    idle(200);
    reg_write(2'd1, 8'd20);   // R10: clear still happens under hush
    idle(50);
    reg_write(2'd0, 8'h1A);
    idle(100);
    reg_write(2'd0, 8'h1E);
    idle(100);

    // fast PWM, buffered compare (R6, R8)
    reg_write(2'd2, 8'd64);
    reg_write(2'd0, 8'h1B);
    idle(600);
    reg_write(2'd2, 8'd200);
    rd_chk(2, 200, "R8");
    idle(600);
    reg_write(2'd0, 8'h1F);
    idle(600);
    reg_write(2'd2, 8'd0);
    idle(600);
    reg_write(2'd2, 8'd255);
    idle(600);
    reg_write(2'd0, 8'h17);   // output code 1 silent in PWM (R9)
    idle(300);

    // dual-slope PWM (R7, R8)
    reg_write(2'd2, 8'd100);
    reg_write(2'd0, 8'h19);
    idle(1100);
    reg_write(2'd0, 8'h1D);
    idle(600);
    reg_write(2'd2, 8'd0);
    idle(600);
    reg_write(2'd2, 8'd255);
    idle(600);
    reg_write(2'd1, 8'd255);
    idle(300);
    reg_write(2'd1, 8'd0);
    idle(300);

    // prescaled sources (R2)
    reg_write(2'd0, 8'h20); idle(300);
    reg_write(2'd0, 8'h30); idle(700);
    reg_write(2'd0, 8'h40); idle(1100);
    reg_write(2'd0, 8'h50); idle(3200);
    reg_write(2'd0, 8'h00);
    reg_write(2'd1, 8'd77);
    idle(20);
    rd_chk(1, 77, "R2");

    // external edges after synchronizer (R2)
    reg_write(2'd0, 8'h70);
    reg_write(2'd1, 8'd0);
    pulses(5);
    idle(6);
    rd_chk(1, 5, "R2");
    reg_write(2'd0, 8'h60);
    reg_write(2'd1, 8'd0);
    pulses(4);
    idle(6);
    rd_chk(1, 4, "R2");

    idle(4);
    finish_run();
  end
endmodule